// File: doc/BRIEF.md
# Request-Paced DMA Bus Master

This engine copies a block of data words between a host-memory port and a local-bus device port. Before each run, software presents a source address, a destination address, a beat count, a direction, an address mode and a pacing mode on the configuration inputs. A one-cycle `start` pulse captures all of them. Each beat reads one word from the source port, holds it in an internal register and writes it to the destination port. Both ports use a plain request/ready handshake. A cycle with both request and ready high completes the access.

The local-side address either stays constant for the whole run, which suits FIFO-style devices, or advances by the beat size. The beat size is one byte for a narrow bus and two bytes for a wide bus. The host-side address always advances by the beat size. In paced mode, every beat waits until the device request line belonging to the selected chip select is high. The request lines are asynchronous and pass through a two-flop synchronizer before the engine looks at them. When the count is used up, the engine raises a sticky done flag and pulses an interrupt for one cycle. An abort input ends the run once the current beat has finished and sets a sticky aborted flag.

The controller has four states:
- **IDLE**: waiting for `start`.
- **GATE**: deciding whether the next beat may begin.
- **READ**: the source access is in progress.
- **WRITE**: the destination access is in progress.

Its transitions are:
- **IDLE→GATE**: start with a non-zero count.
- **IDLE→IDLE**: start with a zero count, which completes at once.
- **GATE→IDLE**: abort.
- **GATE→READ**: the beat is allowed to begin.
- **READ→WRITE**: the source access is accepted.
- **WRITE→GATE**: more beats remain.
- **WRITE→IDLE (done)**: the last beat is finished.
- **WRITE→IDLE (aborted)**: an abort is pending.

Top module: `rqdma_top`

## Requirements
- R1: After reset the engine is idle. `busy`, `done`, `aborted`, `irq`, `hm_req` and `lb_req` are all 0.
- R2: A `start` pulse in IDLE with a non-zero `cfg_len` makes `busy` high from the next cycle. Each beat reads one word, then writes that same word. At most one port request is high in any cycle.
- R3: `cfg_to_host`=0 reads from the host port and writes to the local port. `cfg_to_host`=1 reads from the local port and writes to the host port. `*_we` is 1 only during the write access.
- R4: With `cfg_hold_lcl`=1, `lb_addr` holds the captured local start address for the whole run.
- R5: With `cfg_hold_lcl`=0, the local address advances after each beat. The step is 1 when `cfg_wide`=0 and 2 when `cfg_wide`=1. The host address always advances by that same step.
- R6: With `cfg_paced`=1, a beat begins only when the selected request line, delayed by two flops, is high.
- R7: The request line used is `dev_req[cfg_cs]`, and the other line has no effect. `lb_sel` carries the captured `cfg_cs`.
- R8: When the final beat's write is accepted, `done` rises on the next cycle, `busy` falls and `irq` is high for exactly one cycle.
- R9: An `abort` pulse in READ or WRITE ends the run after the current beat. An `abort` pulse in GATE ends it on the next edge. In both cases `aborted`=1 and `done`=0, with no `irq`. An abort in IDLE has no effect. If the last beat finishes while an abort is pending, done wins.
- R10: A `start` pulse with `cfg_len`=0 raises `done` and `irq` on the next cycle and issues no bus access.
- R11: `start` pulses and configuration changes during a run are ignored.
- R12: An accepted `start` clears `done` and `aborted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_len | input | LW | Beat count |
| cfg_to_host | input | 1 | 0: host to local, 1: local to host |
| cfg_hold_lcl | input | 1 | 1: local address fixed |
| cfg_wide | input | 1 | 1: two-byte beats |
| cfg_paced | input | 1 | 1: each beat waits for a device request |
| cfg_cs | input | CSW | Chip select / request line index |
| start | input | 1 | Start pulse |
| abort | input | 1 | Abort pulse |
| dev_req | input | NCS | Asynchronous device request lines |
| hm_req | output | 1 | Host port request |
| hm_we | output | 1 | Host port write enable |
| hm_addr | output | AW | Host port address |
| hm_wdata | output | DW | Host port write data |
| hm_rdata | input | DW | Host port read data |
| hm_ready | input | 1 | Host port ready |
| lb_req | output | 1 | Local port request |
| lb_we | output | 1 | Local port write enable |
| lb_sel | output | CSW | Local chip select |
| lb_addr | output | AW | Local port address |
| lb_wdata | output | DW | Local port write data |
| lb_rdata | input | DW | Local port read data |
| lb_ready | input | 1 | Local port ready |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky completion flag |
| aborted | output | 1 | Sticky abort flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The assertions take for granted that a port raises ready only while its request is high. They also assume that `start` and `abort` are single-cycle pulses and that `dev_req` may change at any time.

The bench drives every input at the falling clock edge. Its port models assert ready for one cycle after a programmed delay, and only while the matching request is up. The request lines change only between windows that the reference model tracks through its own two-stage delay.

// File: rtl/rqdma_pkg.sv
package rqdma_pkg;

    typedef enum logic [1:0] {
        RQ_IDLE  = 2'd0,
        RQ_GATE  = 2'd1,
        RQ_READ  = 2'd2,
        RQ_WRITE = 2'd3
    } rq_state_e;

    // width of the chip-select index for a given number of request lines
    function automatic int sel_width(input int lines);
        return (lines > 1) ? $clog2(lines) : 1;
    endfunction

endpackage

// File: rtl/rqdma_sync.sv
module rqdma_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] async_in,
    output logic [LINES-1:0] sync_out
);

    generate
        for (genvar i = 0; i < LINES; i++) begin : g_line
            logic [STAGES-1:0] shreg;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shreg <= '0;
                end else begin
                    shreg <= {shreg[STAGES-2:0], async_in[i]};
                end
            end

            assign sync_out[i] = shreg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/rqdma_ctrl.sv
module rqdma_ctrl
    import rqdma_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      len_zero,
    input  logic      abort,
    input  logic      go,
    input  logic      src_ack,
    input  logic      dst_ack,
    input  logic      last_beat,
    output rq_state_e st,
    output logic      load,
    output logic      capture,
    output logic      advance,
    output logic      in_read,
    output logic      in_write,
    output logic      busy,
    output logic      done,
    output logic      aborted,
    output logic      irq
);

    rq_state_e st_q, st_n;
    logic      pend_q;
    logic      fin_ok, fin_abt, zero_done, stop_req;

    assign stop_req = abort | pend_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RQ_IDLE;
        end else begin
            st_q <= st_n;
        end
    end

    // next state and strobes
    always_comb begin
        st_n      = st_q;
        load      = 1'b0;
        capture   = 1'b0;
        advance   = 1'b0;
        fin_ok    = 1'b0;
        fin_abt   = 1'b0;
        zero_done = 1'b0;
        unique case (st_q)
            RQ_IDLE: begin
                if (start) begin
                    if (len_zero) begin
                        zero_done = 1'b1;
                    end else begin
                        load = 1'b1;
                        st_n = RQ_GATE;
                    end
                end
            end
            RQ_GATE: begin
                if (stop_req) begin
                    fin_abt = 1'b1;
                    st_n    = RQ_IDLE;
                end else if (go) begin
                    st_n = RQ_READ;
                end
            end
            RQ_READ: begin
                if (src_ack) begin
                    capture = 1'b1;
                    st_n    = RQ_WRITE;
                end
            end
            RQ_WRITE: begin
                if (dst_ack) begin
                    advance = 1'b1;
                    if (last_beat) begin
                        fin_ok = 1'b1;
                        st_n   = RQ_IDLE;
                    end else if (stop_req) begin
                        fin_abt = 1'b1;
                        st_n    = RQ_IDLE;
                    end else begin
                        st_n = RQ_GATE;
                    end
                end
            end
            default: st_n = RQ_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        in_read  = (st_q == RQ_READ);
        in_write = (st_q == RQ_WRITE);
        busy     = (st_q != RQ_IDLE);
        st       = st_q;
    end

    // abort latch and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            done    <= 1'b0;
            aborted <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (st_n == RQ_IDLE) begin
                pend_q <= 1'b0;
            end else if (abort && (st_q != RQ_IDLE)) begin
                pend_q <= 1'b1;
            end

            if (load) begin
                done <= 1'b0;
            end else if (fin_ok || zero_done) begin
                done <= 1'b1;
            end

            if (load || zero_done) begin
                aborted <= 1'b0;
            end else if (fin_abt) begin
                aborted <= 1'b1;
            end

            irq <= fin_ok | zero_done;
        end
    end

endmodule

// File: rtl/rqdma_path.sv
module rqdma_path #(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int LW  = 8,
    parameter int NCS = 2,
    localparam int CSW = rqdma_pkg::sel_width(NCS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [LW-1:0]  cfg_len,
    input  logic           cfg_to_host,
    input  logic           cfg_hold_lcl,
    input  logic           cfg_wide,
    input  logic           cfg_paced,
    input  logic [CSW-1:0] cfg_cs,
    input  logic           load,
    input  logic           capture,
    input  logic           advance,
    input  logic           in_read,
    input  logic           in_write,
    input  logic [NCS-1:0] req_sync,
    output logic           go,
    output logic           last_beat,
    output logic           len_zero,
    output logic           src_ack,
    output logic           dst_ack,
    output logic           fixed_q,
    output logic           paced_q,
    output logic           req_sel,
    output logic           hm_req,
    output logic           hm_we,
    output logic [AW-1:0]  hm_addr,
    output logic [DW-1:0]  hm_wdata,
    input  logic [DW-1:0]  hm_rdata,
    input  logic           hm_ready,
    output logic           lb_req,
    output logic           lb_we,
    output logic [CSW-1:0] lb_sel,
    output logic [AW-1:0]  lb_addr,
    output logic [DW-1:0]  lb_wdata,
    input  logic [DW-1:0]  lb_rdata,
    input  logic           lb_ready
);

    localparam logic [LW-1:0] ONE_BEAT = LW'(1);

    logic           dir_q, wide_q;
    logic [CSW-1:0] cs_q;
    logic [AW-1:0]  haddr_q, laddr_q, step;
    logic [LW-1:0]  cnt_q;
    logic [DW-1:0]  data_q;

    assign step = wide_q ? AW'(2) : AW'(1);

    // run configuration, captured once per run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            wide_q  <= 1'b0;
            fixed_q <= 1'b0;
            paced_q <= 1'b0;
            cs_q    <= '0;
        end else if (load) begin
            dir_q   <= cfg_to_host;
            wide_q  <= cfg_wide;
            fixed_q <= cfg_hold_lcl;
            paced_q <= cfg_paced;
            cs_q    <= cfg_cs;
        end
    end

    // address and count counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            haddr_q <= '0;
            laddr_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            haddr_q <= cfg_to_host ? cfg_dst : cfg_src;
            laddr_q <= cfg_to_host ? cfg_src : cfg_dst;
            cnt_q   <= cfg_len;
        end else if (advance) begin
            haddr_q <= haddr_q + step;
            if (!fixed_q) begin
                laddr_q <= laddr_q + step;
            end
            cnt_q <= cnt_q - ONE_BEAT;
        end
    end

    // beat holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= dir_q ? lb_rdata : hm_rdata;
        end
    end

    assign req_sel   = req_sync[cs_q];
    assign go        = !paced_q || req_sel;
    assign last_beat = (cnt_q == ONE_BEAT);
    assign len_zero  = (cfg_len == '0);

    assign src_ack = dir_q ? lb_ready : hm_ready;
    assign dst_ack = dir_q ? hm_ready : lb_ready;

    assign hm_req   = (in_read && !dir_q) || (in_write && dir_q);
    assign hm_we    = in_write && dir_q;
    assign hm_addr  = haddr_q;
    assign hm_wdata = data_q;

    assign lb_req   = (in_read && dir_q) || (in_write && !dir_q);
    assign lb_we    = in_write && !dir_q;
    assign lb_sel   = cs_q;
    assign lb_addr  = laddr_q;
    assign lb_wdata = data_q;

endmodule

// File: rtl/rqdma_top.sv
module rqdma_top
    import rqdma_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 16,
    parameter int LW     = 8,
    parameter int NCS    = 2,
    parameter int STAGES = 2,
    localparam int CSW   = sel_width(NCS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  cfg_src,
    input  logic [AW-1:0]  cfg_dst,
    input  logic [LW-1:0]  cfg_len,
    input  logic           cfg_to_host,
    input  logic           cfg_hold_lcl,
    input  logic           cfg_wide,
    input  logic           cfg_paced,
    input  logic [CSW-1:0] cfg_cs,
    input  logic           start,
    input  logic           abort,
    input  logic [NCS-1:0] dev_req,
    output logic           hm_req,
    output logic           hm_we,
    output logic [AW-1:0]  hm_addr,
    output logic [DW-1:0]  hm_wdata,
    input  logic [DW-1:0]  hm_rdata,
    input  logic           hm_ready,
    output logic           lb_req,
    output logic           lb_we,
    output logic [CSW-1:0] lb_sel,
    output logic [AW-1:0]  lb_addr,
    output logic [DW-1:0]  lb_wdata,
    input  logic [DW-1:0]  lb_rdata,
    input  logic           lb_ready,
    output logic           busy,
    output logic           done,
    output logic           aborted,
    output logic           irq
);

    rq_state_e      st;
    logic           load, capture, advance, in_read, in_write;
    logic           go, last_beat, len_zero, src_ack, dst_ack;
    logic           fixed_q, paced_q, req_sel;
    logic [NCS-1:0] req_sync;

    rqdma_sync #(.LINES(NCS), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (dev_req),
        .sync_out (req_sync)
    );

    rqdma_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len_zero  (len_zero),
        .abort     (abort),
        .go        (go),
        .src_ack   (src_ack),
        .dst_ack   (dst_ack),
        .last_beat (last_beat),
        .st        (st),
        .load      (load),
        .capture   (capture),
        .advance   (advance),
        .in_read   (in_read),
        .in_write  (in_write),
        .busy      (busy),
        .done      (done),
        .aborted   (aborted),
        .irq       (irq)
    );

    rqdma_path #(.AW(AW), .DW(DW), .LW(LW), .NCS(NCS)) u_path (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_src      (cfg_src),
        .cfg_dst      (cfg_dst),
        .cfg_len      (cfg_len),
        .cfg_to_host  (cfg_to_host),
        .cfg_hold_lcl (cfg_hold_lcl),
        .cfg_wide     (cfg_wide),
        .cfg_paced    (cfg_paced),
        .cfg_cs       (cfg_cs),
        .load         (load),
        .capture      (capture),
        .advance      (advance),
        .in_read      (in_read),
        .in_write     (in_write),
        .req_sync     (req_sync),
        .go           (go),
        .last_beat    (last_beat),
        .len_zero     (len_zero),
        .src_ack      (src_ack),
        .dst_ack      (dst_ack),
        .fixed_q      (fixed_q),
        .paced_q      (paced_q),
        .req_sel      (req_sel),
        .hm_req       (hm_req),
        .hm_we        (hm_we),
        .hm_addr      (hm_addr),
        .hm_wdata     (hm_wdata),
        .hm_rdata     (hm_rdata),
        .hm_ready     (hm_ready),
        .lb_req       (lb_req),
        .lb_we        (lb_we),
        .lb_sel       (lb_sel),
        .lb_addr      (lb_addr),
        .lb_wdata     (lb_wdata),
        .lb_rdata     (lb_rdata),
        .lb_ready     (lb_ready)
    );

endmodule

// File: rtl/rqdma_chk.sv
module rqdma_chk
    import rqdma_pkg::*;
#(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hm_req,
    input logic          lb_req,
    input logic          busy,
    input logic          done,
    input logic          aborted,
    input logic          irq,
    input logic [AW-1:0] lb_addr,
    input logic          fixed_q,
    input logic          paced_q,
    input logic          req_sel,
    input rq_state_e     st
);

    // R2
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hm_req, lb_req}));

    // R4
    fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && fixed_q) |-> $stable(lb_addr));

    // R6
    paced_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paced_q && ($past(st) == RQ_GATE) && (st == RQ_READ)) |-> $past(req_sel));

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R8
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && !busy));

    // R9
    abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aborted |-> !done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!hm_req && !lb_req));

endmodule

bind rqdma_top rqdma_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hm_req  (hm_req),
    .lb_req  (lb_req),
    .busy    (busy),
    .done    (done),
    .aborted (aborted),
    .irq     (irq),
    .lb_addr (lb_addr),
    .fixed_q (fixed_q),
    .paced_q (paced_q),
    .req_sel (req_sel),
    .st      (st)
);

// File: tb/sim_rqdma_top.sv
module sim_rqdma_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_src = '0, cfg_dst = '0;
    logic [7:0]  cfg_len = '0;
    logic        cfg_to_host = 0, cfg_hold_lcl = 0, cfg_wide = 0, cfg_paced = 0;
    logic [0:0]  cfg_cs = '0;
    logic        start = 0, abort = 0;
    logic [1:0]  dev_req = '0;
    logic        hm_req, hm_we, lb_req, lb_we, busy, done, aborted, irq;
    logic [15:0] hm_addr, hm_wdata, lb_addr, lb_wdata;
    logic [15:0] hm_rdata = '0, lb_rdata = '0;
    logic        hm_ready = 0, lb_ready = 0;
    logic [0:0]  lb_sel;

    always #(CLK_P/2) clk = ~clk;

    rqdma_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_len(cfg_len),
        .cfg_to_host(cfg_to_host), .cfg_hold_lcl(cfg_hold_lcl), .cfg_wide(cfg_wide),
        .cfg_paced(cfg_paced), .cfg_cs(cfg_cs), .start(start), .abort(abort), .dev_req(dev_req),
        .hm_req(hm_req), .hm_we(hm_we), .hm_addr(hm_addr), .hm_wdata(hm_wdata),
        .hm_rdata(hm_rdata), .hm_ready(hm_ready), .lb_req(lb_req), .lb_we(lb_we),
        .lb_sel(lb_sel), .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata),
        .lb_ready(lb_ready), .busy(busy), .done(done), .aborted(aborted), .irq(irq)
    );

    int compared = 0, mismatched = 0;
    int irq_cnt = 0, busreq_cnt = 0;
    int hdly = 1, ldly = 2, hwait = 0, lwait = 0;
    logic [15:0] hmem [0:255];
    logic [15:0] lmem [0:255];

    task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_ph = 0;      // 0 idle, 1 gate, 2 read, 3 write
    int          m_cnt = 0;
    logic [15:0] m_ha = '0, m_la = '0, m_data = '0;
    int          m_step = 1;
    logic        m_dir = 0, m_fix = 0, m_pace = 0, m_cs = 0, m_pend = 0;
    logic        m_done = 0, m_abt = 0, m_irq = 0;
    logic [1:0]  m_s1 = '0, m_s2 = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_ha = '0; m_la = '0; m_data = '0; m_step = 1;
            m_dir = 0; m_fix = 0; m_pace = 0; m_cs = 0; m_pend = 0;
            m_done = 0; m_abt = 0; m_irq = 0; m_s1 = '0; m_s2 = '0;
        end else begin
            logic stop;
            stop  = abort || m_pend;
            m_irq = 0;
            case (m_ph)
                0: if (start) begin
                    if (cfg_len == 0) begin
                        m_done = 1; m_irq = 1; m_abt = 0;
                    end else begin
                        m_ph = 1; m_cnt = cfg_len; m_dir = cfg_to_host; m_fix = cfg_hold_lcl;
                        m_pace = cfg_paced; m_cs = cfg_cs[0]; m_step = cfg_wide ? 2 : 1;
                        m_ha = cfg_to_host ? cfg_dst : cfg_src;
                        m_la = cfg_to_host ? cfg_src : cfg_dst;
                        m_done = 0; m_abt = 0; m_pend = 0;
                    end
                end
                1: begin
                    if (stop) begin m_ph = 0; m_abt = 1; m_pend = 0; end
                    else if (!m_pace || m_s2[m_cs]) m_ph = 2;
                end
                2: begin
                    if (m_dir ? lb_ready : hm_ready) begin
                        m_data = m_dir ? lb_rdata : hm_rdata; m_ph = 3;
                    end
                    if (abort) m_pend = 1;
                end
                default: begin
                    if (m_dir ? hm_ready : lb_ready) begin
                        m_ha = m_ha + 16'(m_step);
                        if (!m_fix) m_la = m_la + 16'(m_step);
                        if (m_cnt == 1) begin m_done = 1; m_irq = 1; m_ph = 0; m_pend = 0; end
                        else if (stop) begin m_abt = 1; m_ph = 0; m_pend = 0; end
                        else m_ph = 1;
                        m_cnt = m_cnt - 1;
                    end else if (abort) m_pend = 1;
                end
            endcase
            m_s2 = m_s1;
            m_s1 = dev_req;
        end
    end

    // ---------------- per-cycle comparison and port models ----------------
    always @(negedge clk) begin
        logic e_hreq, e_lreq, e_hwe, e_lwe;
        e_hreq = (m_ph == 2 && !m_dir) || (m_ph == 3 && m_dir);
        e_lreq = (m_ph == 2 && m_dir) || (m_ph == 3 && !m_dir);
        e_hwe  = (m_ph == 3 && m_dir);
        e_lwe  = (m_ph == 3 && !m_dir);
        chk("R2", "busy", busy, m_ph != 0);
        chk("R8", "done", done, m_done);
        chk("R9", "aborted", aborted, m_abt);
        chk("R8", "irq", irq, m_irq);
        chk("R3", "hm_req", hm_req, e_hreq);
        chk("R3", "lb_req", lb_req, e_lreq);
        chk("R3", "hm_we", hm_we, e_hwe);
        chk("R3", "lb_we", lb_we, e_lwe);
        if (e_hreq) chk("R5", "hm_addr", hm_addr, m_ha);
        if (e_lreq) chk("R5", "lb_addr", lb_addr, m_la);
        if (e_lreq) chk("R7", "lb_sel", lb_sel, m_cs);
        if (e_hwe)  chk("R2", "hm_wdata", hm_wdata, m_data);
        if (e_lwe)  chk("R2", "lb_wdata", lb_wdata, m_data);
        if (irq) irq_cnt++;
        if (hm_req || lb_req) busreq_cnt++;

        if (hm_ready) begin hm_ready = 0; hwait = 0; end
        else if (hm_req) begin
            if (hwait >= hdly) begin
                hm_ready = 1;
                if (hm_we) hmem[hm_addr[7:0]] = hm_wdata;
                else hm_rdata = hmem[hm_addr[7:0]];
            end else hwait++;
        end else hwait = 0;

        if (lb_ready) begin lb_ready = 0; lwait = 0; end
        else if (lb_req) begin
            if (lwait >= ldly) begin
                lb_ready = 1;
                if (lb_we) lmem[lb_addr[7:0]] = lb_wdata;
                else lb_rdata = lmem[lb_addr[7:0]];
            end else lwait++;
        end else lwait = 0;
    end

    task automatic setup(input logic [15:0] s, input logic [15:0] d, input logic [7:0] n,
                         input logic th, input logic hold, input logic wide, input logic pace, input logic cs);
        cfg_src = s; cfg_dst = d; cfg_len = n; cfg_to_host = th;
        cfg_hold_lcl = hold; cfg_wide = wide; cfg_paced = pace; cfg_cs = cs;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort = 1;
        @(negedge clk); abort = 0;
    endtask

    task automatic wait_idle(input string tag);
        int n;
        n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        if (busy) begin
            mismatched++;
            $display("FAIL %s run did not end actual=busy expected=idle", tag);
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            hmem[i] = 16'hA000 + 16'(i);
            lmem[i] = 16'h5000 + 16'(i);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "req", {hm_req, lb_req}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "irq/aborted", {irq, aborted}, 0);

        // host to local, incrementing, wide beats
        setup(16'h0010, 16'h0040, 8'd4, 0, 0, 1, 0, 0);
        pulse_start();
        chk("R2", "busy after start", busy, 1);
        wait_idle("R2");
        chk("R5", "lmem[46]", lmem[8'h46], 16'hA016);
        chk("R3", "lmem[40]", lmem[8'h40], 16'hA010);
        chk("R8", "done", done, 1);

        // local to host, fixed local address, narrow
        hdly = 3; ldly = 0;
        lmem[8'h80] = 16'h1234;
        setup(16'h0080, 16'h0030, 8'd3, 1, 1, 0, 0, 0);
        pulse_start();
        wait_idle("R4");
        chk("R4", "hmem[32]", hmem[8'h32], 16'h1234);
        chk("R3", "hmem[30]", hmem[8'h30], 16'h1234);

        // paced on line 1 while only line 0 is asserted
        hdly = 0; ldly = 1;
        dev_req = 2'b01;
        setup(16'h0020, 16'h0060, 8'd2, 0, 0, 0, 1, 1);
        pulse_start();
        busreq_cnt = 0;
        repeat (30) @(negedge clk);
        chk("R7", "requests while other line high", busreq_cnt, 0);
        chk("R6", "busy while waiting", busy, 1);
        dev_req = 2'b10;
        wait_idle("R6");
        chk("R6", "lmem[61]", lmem[8'h61], 16'hA021);
        dev_req = 2'b00;

        // abort mid-run
        setup(16'h0000, 16'h00D0, 8'd10, 0, 0, 0, 0, 0);
        pulse_start();
        repeat (6) @(negedge clk);
        pulse_abort();
        wait_idle("R9");
        chk("R9", "aborted", aborted, 1);
        chk("R9", "done", done, 0);
        chk("R9", "lmem[D9] untouched", lmem[8'hD9], 16'h50D9);

        // zero-length start
        setup(16'h0000, 16'h0000, 8'd0, 0, 0, 0, 0, 0);
        pulse_start();
        chk("R10", "done", done, 1);
        chk("R10", "irq", irq, 1);
        chk("R10", "busy", busy, 0);
        chk("R12", "aborted cleared", aborted, 0);

        // start and config changes during a run
        setup(16'h0050, 16'h00B0, 8'd3, 0, 0, 0, 0, 0);
        pulse_start();
        repeat (3) @(negedge clk);
        setup(16'h0050, 16'h00C0, 8'd8, 0, 0, 1, 0, 0);
        pulse_start();
        wait_idle("R11");
        chk("R11", "lmem[C0] untouched", lmem[8'hC0], 16'h50C0);
        chk("R11", "lmem[B2]", lmem[8'hB2], 16'hA052);

        // abort while idle
        pulse_abort();
        chk("R9", "idle abort ignored", {aborted, done, busy}, 3'b010);

        // abort while gated in paced mode
        setup(16'h0000, 16'h00E0, 8'd4, 0, 0, 0, 1, 0);
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_abort();
        chk("R9", "gate abort", {busy, aborted}, 2'b01);

        // flags cleared by a new start
        setup(16'h0001, 16'h00F0, 8'd1, 0, 0, 0, 0, 0);
        pulse_start();
        chk("R12", "aborted cleared", aborted, 0);
        chk("R12", "busy", busy, 1);
        wait_idle("R12");
        chk("R8", "irq pulse count", irq_cnt, 6);

        summary();
        $finish;
    end
endmodule